// File: doc/BRIEF.md
# Five-Level Integrate-and-Reset PWM Leg Generator

This block drives one phase leg of a five-level diode-clamped rectifier. It builds four digital carriers that rise together in phase. Each carrier rises from its own dc offset up to an amplitude word, so the four carriers stack into bands that cover the signed reference range. The amplitude words come from the capacitor balancing loops, which are outside this block.

A cycle-start strobe opens every switching cycle. On that strobe the block does three things:
- it samples the amplitudes;
- it decides which band holds the control reference;
- it latches a gate pattern that fixes which upper switches are held on, which are held off, and which one is pulse-width modulated.

The modulated switch turns on at cycle start. It turns off on the first clock on which its carrier has climbed to the reference, and that same event clears its integrator.

Each lower gate is the complement of its upper gate. The block also brings out a two-bit region code and the four carrier values, so that a monitor can observe the modulation.

Top module: `occ5_pwm_leg`

## Requirements
- R1: While `rst` is high, the next clock edge drives all `gate_up` bits to 0, all `gate_lo` bits to 1, `region` to 0, and every carrier to 0.
- R2: `gate_lo[k]` is always the inverse of `gate_up[k]`.
- R3: On a clock edge with `cyc_start` high, the block latches `region`:
  - 0 when `ref_in` > A2;
  - 1 when 0 < `ref_in` ≤ A2;
  - 2 when -A3 < `ref_in` ≤ 0;
  - 3 otherwise.
  
  The code then holds until the next start, whatever `ref_in` does in between. Ak is `amp_in[k-1]`.
- R4: Switch k is `gate_up[k-1]`, and region code r is region number r+1.
  - Switches with k < r+1 are held off for the whole cycle.
  - Switches with k > r+1 are held on for the whole cycle.
  - Switch k = r+1 is modulated.
- R5: The modulated switch is high from the start edge until its carrier reaches the reference. With N = 2^CYC_LOG2, its high time is ceil((ref - offset)·N / amplitude) clocks.
- R6: A carrier stops rising at its amplitude. A reference that is above the modulated band, at start or later in the cycle, keeps that switch on until the next start.
- R7: The carrier offsets are stacked from the band amplitudes:

  | Channel | Offset |
  |---|---|
  | 1 | A2 |
  | 2 | 0 |
  | 3 | -A3 |
  | 4 | -(A3+A4) |

- R8: Amplitudes are sampled only at cycle start. A change of `amp_in` during a cycle does not affect the gates or carriers before the next start.
- R9: `carrier[k]` equals its offset plus floor(step count × amplitude / N). The step count is capped at N, and the value is 0 above the offset when the channel is not rising.
- R10: Once the modulated pulse has ended, it stays low until the next start, even if the reference moves back above the carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe that opens a switching cycle |
| ref_in | input | REF_W | Signed control reference (scaled current sense plus current reference) |
| amp_in | input | 4×AMP_W | Unsigned band amplitudes, index 0 is the top band |
| gate_up | output | 4 | Upper switch gates, bit 0 is the outermost switch |
| gate_lo | output | 4 | Complementary lower gates |
| region | output | 2 | Latched region code, 0 to 3 |
| carrier | output | 4×(AMP_W+3) | Signed carrier values for monitoring |

## Verification
The assertions assume the following about the inputs:
- `cyc_start` is a single-clock strobe.
- The amplitude words are small enough that the stacked bands fit the carrier width.
- No switching cycle is longer than N clocks, so the carrier bound holds.

The stimulus issues a start exactly every N clocks. It keeps the amplitudes within a few hundred counts and the reference within slightly more than the stacked span. In some cycles it moves the reference or the amplitudes in the middle of the cycle on purpose, to exercise the latching rules.

// File: rtl/occ5_pkg.sv
package occ5_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    REG_I   = 2'd0,
    REG_II  = 2'd1,
    REG_III = 2'd2,
    REG_IV  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CH_OFF = 2'd0,
    CH_ON  = 2'd1,
    CH_MOD = 2'd2
  } chan_mode_e;
endpackage

// File: rtl/occ5_offset_stack.sv
module occ5_offset_stack
  import occ5_pkg::*;
#(
  parameter int AMP_W = 14,
  parameter int CAR_W = AMP_W + 3
) (
  input  logic [NUM_CH-1:0][AMP_W-1:0] amp,
  output logic signed [CAR_W-1:0]      off [NUM_CH]
);
  // Bottom of the stack sits at minus the lower half of the bands; each
  // channel's offset is that floor plus every amplitude stacked beneath it.
  always_comb begin
    logic signed [CAR_W-1:0] run;
    run = '0;
    for (int k = NUM_CH / 2; k < NUM_CH; k++)
      run = run - $signed(CAR_W'(amp[k]));
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      off[k] = run;
      run    = run + $signed(CAR_W'(amp[k]));
    end
  end
endmodule

// File: rtl/occ5_region_sel.sv
module occ5_region_sel
  import occ5_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CAR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cyc_start,
  input  logic signed [REF_W-1:0]  ref_in,
  input  logic signed [CAR_W-1:0]  off [NUM_CH],
  output chan_mode_e               mode_next [NUM_CH],
  output region_e                  region_q
);
  localparam int SW = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;

  logic signed [SW-1:0] ref_x;
  logic [1:0]           above_cnt;

  // Region index = number of band floors (top three) the reference does not exceed.
  always_comb begin
    ref_x     = SW'(ref_in);
    above_cnt = '0;
    for (int k = 0; k < NUM_CH - 1; k++)
      if (ref_x <= SW'(off[k])) above_cnt = above_cnt + 2'd1;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_mode
    always_comb begin
      if (k < int'(above_cnt))       mode_next[k] = CH_OFF;
      else if (k == int'(above_cnt)) mode_next[k] = CH_MOD;
      else                           mode_next[k] = CH_ON;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            region_q <= REG_I;
    else if (cyc_start) region_q <= region_e'(above_cnt);
  end

  assert_region_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(region_q));
endmodule

// File: rtl/occ5_carrier_chan.sv
module occ5_carrier_chan
  import occ5_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int AMP_W    = 14,
  parameter int CYC_LOG2 = 6,
  parameter int CAR_W    = AMP_W + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_start,
  input  chan_mode_e              mode_in,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [AMP_W-1:0]        amp,
  input  logic signed [CAR_W-1:0] off,
  output logic                    gate,
  output logic [AMP_W-1:0]        ramp
);
  localparam int ACC_W = AMP_W + CYC_LOG2;
  localparam int CMP_W = ((REF_W > CAR_W) ? REF_W : CAR_W) + CYC_LOG2 + 1;

  chan_mode_e           mode_q;
  logic                 gate_q;
  logic [ACC_W-1:0]     acc_q;
  logic [ACC_W-1:0]     amp_full;
  logic [ACC_W:0]       acc_step;
  logic [ACC_W-1:0]     acc_sat;
  logic signed [CMP_W-1:0] ref_s, off_s, car_s;
  logic                 hit_now, hit_zero;

  // Work in units of 1/N of a reference count so each step is exact.
  always_comb begin
    amp_full = {amp, {CYC_LOG2{1'b0}}};
    acc_step = {1'b0, acc_q} + (ACC_W + 1)'(amp);
    acc_sat  = (acc_step > {1'b0, amp_full}) ? amp_full : acc_step[ACC_W-1:0];
    ref_s    = CMP_W'(ref_in) <<< CYC_LOG2;
    off_s    = CMP_W'(off) <<< CYC_LOG2;
    car_s    = off_s + $signed(CMP_W'(acc_q));
    hit_now  = (car_s >= ref_s);
    hit_zero = (off_s >= ref_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CH_OFF;
      gate_q <= 1'b0;
      acc_q  <= '0;
    end else if (cyc_start) begin
      mode_q <= mode_in;
      unique case (mode_in)
        CH_ON: begin
          gate_q <= 1'b1;
          acc_q  <= '0;
        end
        CH_MOD: begin
          gate_q <= !hit_zero;
          acc_q  <= hit_zero ? '0 : ACC_W'(amp);
        end
        default: begin
          gate_q <= 1'b0;
          acc_q  <= '0;
        end
      endcase
    end else if (mode_q == CH_MOD && gate_q) begin
      if (hit_now) begin
        gate_q <= 1'b0;
        acc_q  <= '0;
      end else begin
        acc_q  <= acc_sat;
      end
    end
  end

  assign gate = gate_q;
  assign ramp = acc_q[ACC_W-1:CYC_LOG2];

  assert_pulse_stays_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && !gate_q) |=> !gate_q);

  assert_held_on_R4: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && mode_q == CH_ON) |=> gate_q);

  assert_ramp_capped_R6: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |-> (acc_q <= amp_full));
endmodule

// File: rtl/occ5_pwm_leg.sv
module occ5_pwm_leg
  import occ5_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int AMP_W    = 14,
  parameter int CYC_LOG2 = 6,
  localparam int CAR_W   = AMP_W + 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cyc_start,
  input  logic signed [REF_W-1:0]         ref_in,
  input  logic [NUM_CH-1:0][AMP_W-1:0]    amp_in,
  output logic [NUM_CH-1:0]               gate_up,
  output logic [NUM_CH-1:0]               gate_lo,
  output logic [1:0]                      region,
  output logic [NUM_CH-1:0][CAR_W-1:0]    carrier
);
  logic [NUM_CH-1:0][AMP_W-1:0] amp_q;
  logic [NUM_CH-1:0][AMP_W-1:0] amp_eff;
  logic signed [CAR_W-1:0]      off_eff [NUM_CH];
  logic signed [CAR_W-1:0]      off_q   [NUM_CH];
  chan_mode_e                   mode_next [NUM_CH];
  region_e                      region_q;
  logic [AMP_W-1:0]             ramp [NUM_CH];

  // Amplitudes are frozen for the cycle; at the start edge the new words act at once.
  always_ff @(posedge clk) begin
    if (rst)            amp_q <= '0;
    else if (cyc_start) amp_q <= amp_in;
  end

  assign amp_eff = cyc_start ? amp_in : amp_q;

  occ5_offset_stack #(.AMP_W(AMP_W), .CAR_W(CAR_W)) u_stack_eff (
    .amp (amp_eff),
    .off (off_eff)
  );

  occ5_offset_stack #(.AMP_W(AMP_W), .CAR_W(CAR_W)) u_stack_q (
    .amp (amp_q),
    .off (off_q)
  );

  occ5_region_sel #(.REF_W(REF_W), .CAR_W(CAR_W)) u_region (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .ref_in    (ref_in),
    .off       (off_eff),
    .mode_next (mode_next),
    .region_q  (region_q)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    occ5_carrier_chan #(
      .REF_W    (REF_W),
      .AMP_W    (AMP_W),
      .CYC_LOG2 (CYC_LOG2),
      .CAR_W    (CAR_W)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cyc_start (cyc_start),
      .mode_in   (mode_next[k]),
      .ref_in    (ref_in),
      .amp       (amp_eff[k]),
      .off       (off_eff[k]),
      .gate      (gate_up[k]),
      .ramp      (ramp[k])
    );

    assign carrier[k] = off_q[k] + $signed(CAR_W'(ramp[k]));

    assert_carrier_band_R9: assert property (@(posedge clk) disable iff (rst)
      ($signed(carrier[k]) >= off_q[k]) &&
      ($signed(carrier[k]) <= off_q[k] + $signed(CAR_W'(amp_q[k]))));
  end

  assign gate_lo = ~gate_up;
  assign region  = region_q;

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> (gate_up == '0 && region == 2'd0));

  assert_thermometer_R4: assert property (@(posedge clk) disable iff (rst)
    (gate_up[NUM_CH-2:0] & ~gate_up[NUM_CH-1:1]) == '0);

  assert_amp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(amp_q));
endmodule

// File: tb/occ5_pwm_leg_tb_top.sv
`timescale 1ns/1ps
module occ5_pwm_leg_tb_top;
  localparam int REF_W = 16;
  localparam int AMP_W = 14;
  localparam int CL2   = 6;
  localparam int N     = 1 << CL2;
  localparam int CAR_W = AMP_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic [3:0][AMP_W-1:0] amp_in = '0;
  logic [3:0] gate_up, gate_lo;
  logic [1:0] region;
  logic [3:0][CAR_W-1:0] carrier;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  occ5_pwm_leg #(.REF_W(REF_W), .AMP_W(AMP_W), .CYC_LOG2(CL2)) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .ref_in(ref_in),
    .amp_in(amp_in), .gate_up(gate_up), .gate_lo(gate_lo),
    .region(region), .carrier(carrier)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_amp [4];
  int m_reg;
  int m_mode [4];   // 0 off, 1 on, 2 modulated
  int m_on [4];
  int m_acc [4];    // k*amp, in 1/N units

  function automatic int band_floor(input int k, input int a0, input int a1,
                                    input int a2, input int a3);
    int b;
    b = -(a2 + a3);
    if (k == 3) return b;
    if (k == 2) return b + a3;
    if (k == 1) return b + a3 + a2;
    return b + a3 + a2 + a1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg = 0;
      for (int k = 0; k < 4; k++) begin
        m_amp[k] = 0; m_mode[k] = 0; m_on[k] = 0; m_acc[k] = 0;
      end
    end else if (cyc_start) begin
      int r;
      r = int'(ref_in);
      for (int k = 0; k < 4; k++) m_amp[k] = int'(amp_in[k]);
      if (r > m_amp[1]) m_reg = 0;
      else if (r > 0) m_reg = 1;
      else if (r > -m_amp[2]) m_reg = 2;
      else m_reg = 3;
      for (int k = 0; k < 4; k++) begin
        int f;
        f = band_floor(k, m_amp[0], m_amp[1], m_amp[2], m_amp[3]);
        m_mode[k] = (k < m_reg) ? 0 : (k == m_reg) ? 2 : 1;
        if (m_mode[k] == 1) m_on[k] = 1;
        else if (m_mode[k] == 0) m_on[k] = 0;
        else m_on[k] = (f < r) ? 1 : 0;
        m_acc[k] = (m_mode[k] == 2 && m_on[k] == 1) ? m_amp[k] : 0;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (m_mode[k] == 2 && m_on[k] == 1) begin
          int f;
          f = band_floor(k, m_amp[0], m_amp[1], m_amp[2], m_amp[3]);
          if (f * N + m_acc[k] >= int'(ref_in) * N) begin
            m_on[k] = 0; m_acc[k] = 0;
          end else begin
            m_acc[k] = m_acc[k] + m_amp[k];
            if (m_acc[k] > m_amp[k] * N) m_acc[k] = m_amp[k] * N;
          end
        end
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    int eu;
    int ec;
    eu = 0;
    for (int k = 0; k < 4; k++) eu = eu | (m_on[k] << k);
    check(int'(gate_up) == eu, "R4/R5/R6/R10 gate_up vs model", int'(gate_up), eu);
    check(int'(gate_lo) == ((~eu) & 15), "R2 gate_lo complement", int'(gate_lo), (~eu) & 15);
    check(int'(region) == m_reg, "R3 region vs model", int'(region), m_reg);
    for (int k = 0; k < 4; k++) begin
      ec = band_floor(k, m_amp[0], m_amp[1], m_amp[2], m_amp[3]) + m_acc[k] / N;
      check(int'($signed(carrier[k])) == ec, "R7/R9 carrier vs model",
            int'($signed(carrier[k])), ec);
    end
  end

  // One switching cycle; directed width expectations when do_exp is set.
  task automatic run_cyc(input int r0, input int a0, input int a1, input int a2, input int a3,
                         input int r1, input int na, input int chg, input bit do_exp,
                         input int ereg, input int e0, input int e1, input int e2, input int e3,
                         input string tag);
    int cnt [4];
    int ew [4];
    ew[0] = e0; ew[1] = e1; ew[2] = e2; ew[3] = e3;
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    cyc_start = 1'b1;
    ref_in = REF_W'(r0);
    amp_in[0] = AMP_W'(a0); amp_in[1] = AMP_W'(a1);
    amp_in[2] = AMP_W'(a2); amp_in[3] = AMP_W'(a3);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      if (i == 1) cyc_start = 1'b0;
      for (int k = 0; k < 4; k++) cnt[k] += int'(gate_up[k]);
      if (do_exp && i == N)
        check(int'(region) == ereg, {tag, " R3 latched region"}, int'(region), ereg);
      if (i == chg) begin
        ref_in = REF_W'(r1);
        if (na >= 0) for (int k = 0; k < 4; k++) amp_in[k] = AMP_W'(na);
      end
    end
    if (do_exp)
      for (int k = 0; k < 4; k++)
        check(cnt[k] == ew[k], {tag, " R4/R5 high clocks per switch"}, cnt[k], ew[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gate_up == 4'b0000, "R1 reset gate_up", int'(gate_up), 0);
    check(gate_lo == 4'b1111, "R1 reset gate_lo", int'(gate_lo), 15);
    check(region == 2'd0, "R1 reset region", int'(region), 0);
    check(carrier == '0, "R1 reset carriers", 1, 0);
    rst = 1'b0;
    @(negedge clk);

    // Equal bands of 400 counts
    run_cyc( 600, 400,400,400,400,  600, -1, 0, 1, 0, 32,64,64,64, "R5 region I");
    run_cyc( 100, 400,400,400,400,  100, -1, 0, 1, 1,  0,16,64,64, "R5 region II");
    run_cyc(-100, 400,400,400,400, -100, -1, 0, 1, 2,  0, 0,48,64, "R5 region III");
    run_cyc(-700, 400,400,400,400, -700, -1, 0, 1, 3,  0, 0, 0,16, "R5 region IV");
    run_cyc( 900, 400,400,400,400,  900, -1, 0, 1, 0, 64,64,64,64, "R6 above top band");
    run_cyc(-900, 400,400,400,400, -900, -1, 0, 1, 3,  0, 0, 0, 0, "R5 below bottom band");
    run_cyc(   0, 400,400,400,400,    0, -1, 0, 1, 2,  0, 0,64,64, "R3 tie at zero");
    run_cyc( 400, 400,400,400,400,  400, -1, 0, 1, 1,  0,64,64,64, "R3 tie at A2");
    // Unequal bands: offsets 200, 0, -100, -600 (R7)
    run_cyc( 250, 300,200,100,500,  250, -1, 0, 1, 0, 11,64,64,64, "R7 unequal region I");
    run_cyc( 150, 300,200,100,500,  150, -1, 0, 1, 1,  0,48,64,64, "R7 unequal region II");
    run_cyc( -50, 300,200,100,500,  -50, -1, 0, 1, 2,  0, 0,32,64, "R7 unequal region III");
    run_cyc(-150, 300,200,100,500, -150, -1, 0, 1, 3,  0, 0, 0,58, "R7 unequal region IV");
    // Mid-cycle disturbances
    run_cyc( 100, 400,400,400,400,  600, -1, 5, 1, 1,  0,64,64,64, "R3/R6 ref jumps above band");
    run_cyc( 100, 400,400,400,400,  100,100, 5, 1, 1,  0,16,64,64, "R8 amp change mid-cycle");
    run_cyc( 100, 400,400,400,400,  390, -1,20, 1, 1,  0,16,64,64, "R10 ref returns after end");

    // Random cycles, checked against the model every clock
    for (int c = 0; c < 40; c++) begin
      int a [4];
      int span;
      int r0;
      int r1;
      for (int k = 0; k < 4; k++) a[k] = int'($urandom_range(0, 500));
      span = a[0] + a[1] + a[2] + a[3] + 50;
      r0 = int'($urandom_range(0, 2 * span)) - span;
      r1 = int'($urandom_range(0, 2 * span)) - span;
      run_cyc(r0, a[0], a[1], a[2], a[3], r1,
              (c % 5 == 0) ? int'($urandom_range(0, 500)) : -1,
              (c % 3 == 0) ? int'($urandom_range(2, N - 1)) : 0,
              1'b0, 0, 0, 0, 0, 0, "random");
    end

    // Reset in the middle of a cycle (R1)
    cyc_start = 1'b1; ref_in = 16'sd100;
    for (int k = 0; k < 4; k++) amp_in[k] = 14'd400;
    @(negedge clk); cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(gate_up == 4'b0000, "R1 mid-run reset gate_up", int'(gate_up), 0);
    check(gate_lo == 4'b1111, "R1 mid-run reset gate_lo", int'(gate_lo), 15);
    check(region == 2'd0, "R1 mid-run reset region", int'(region), 0);
    rst = 1'b0;
    @(negedge clk);
    run_cyc(-100, 400,400,400,400, -100, -1, 0, 1, 2,  0, 0,48,64, "R5 after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule